// File: doc/BRIEF.md
# Shift-and-Add 8-Point Forward DCT Row Kernel

This block turns one row of eight signed samples into eight frequency coefficients. The transform approximates the type-II DCT. It contains no multiplier. The datapath opens with sum/difference butterflies. Each plane rotation is then a short chain of lifting steps, and every lifting constant has the form `NUM / 2^SH`. Each such product is a sum of shifted copies of the operand, followed by one arithmetic right shift.

The datapath is a fixed four-register pipeline, and each stage computes its independent operations side by side. A new row can enter on every clock. Its coefficients leave exactly four cycles later, and a valid flag travels with the data. Two of these kernels, with a transpose store between them, make an 8x8 separable 2-D transform. That store and the second pass belong to the surrounding design.

Top module: `bdct_row8`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears every pipeline valid bit. `out_valid` is therefore low after that edge. A row that was in flight at reset, or that was offered while reset was held, never produces `out_valid`.
- R2: `out_valid` at any edge equals `in_valid` four edges earlier. This holds whenever the four intermediate edges were all outside reset. Rows presented on consecutive cycles all come out in order, one per cycle.
- R3: With x lanes as inputs and floor lifting L(v,K)=(v*NUM_K)>>>SH_K, the coefficients are defined as follows.
  - Butterflies: a_i=x_i+x_(7-i) and d_i=x_i-x_(7-i).
  - Even sums and differences: e0=a0+a3, e1=a1+a2, e2=a1-a2, e3=a0-a3.
  - Even outputs: Y0=e0+e1, Y4=(Y0>>>1)-e1, Y6=e2-L(e3,K3), Y2=e3+L(Y6,K4).
  - Odd intermediates: m=d2-L(d1,K1), n=d1+L(m,K2), b0=d0+n, b1=d0-n, b2=d3-m, b3=d3+m.
  - Odd outputs: Y7=L(b0,K5)-b3, Y1=b0-L(Y7,K6), Y5=b1+L(b2,K7), Y3=b2-L(Y5,K8).
- R4: A constant (DC) row of value c gives Y0=8c, and every other coefficient is zero.
- R5: An antisymmetric row (x_i = -x_(7-i)) gives zero on all even coefficients Y0, Y2, Y4 and Y6.
- R6: An all-zero row gives all-zero coefficients.
- R7: Every lifting product rounds toward negative infinity: the shift is arithmetic and truncates. This applies to negative operands too.
- R8: Inputs anywhere in the full 9-bit range -256..255 give exact R3 results with the default coefficients, with no wrap in any intermediate value.
- R9: Cycles with `in_valid` low produce no `out_valid` four cycles later. Gapped rows come out with their gaps preserved. Input lane i sits at `in_vec[i*9 +: 9]` and coefficient k at `out_vec[k*17 +: 17]`, both two's complement.
- R10: The eight lifting constants K1..K8 are parameters, each given as a numerator and a shift amount. An instance built with other values follows R3 with those values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset of the valid pipeline |
| in_valid | input | 1 | Marks `in_vec` as a row to transform this cycle |
| in_vec | input | 8*IN_W (72) | Eight signed samples, lane i at bits i*IN_W |
| out_valid | output | 1 | Marks `out_vec` as a finished coefficient row |
| out_vec | output | 8*OUT_W (136) | Eight signed coefficients, frequency k at bits k*OUT_W |

## Verification
Some properties are checked on every clock:
- the four-cycle valid latency;
- the clearing of the valid flag by reset;
- the structural identities: zero in gives zero out, a DC row puts 8c on Y0 alone, and an antisymmetric row empties the even half.

The exact coefficient values, the floor rounding of negative lifting products, behaviour at the range extremes, and the correctness of a second instance with different constants can only be shown by the bench's scenarios. Each compares every output lane against a model computed from the R3 equations.

// File: rtl/bdct_pkg.sv
// Package: shared constants of the shift-and-add row DCT.
// Assumes: a row is always eight lanes; pipeline depth is fixed at four.
package bdct_pkg;
    localparam int ROW_N   = 8;
    localparam int HALF_N  = ROW_N / 2;
    localparam int PIPE_LAT = 4;
endpackage

// File: rtl/bdct_lift.sv
// Module: one dyadic lifting product y = floor(v * NUM / 2^SH).
// The product is a sum of left-shifted copies of v, one per set bit of NUM.
// Assumes: 0 <= NUM < 2^NUM_BITS and |v*NUM| fits in W signed bits.
module bdct_lift #(
    parameter int W        = 17,
    parameter int NUM      = 1,
    parameter int SH       = 0,
    parameter int NUM_BITS = 8
) (
    input  logic signed [W-1:0] v,
    output logic signed [W-1:0] y
);
    logic signed [W-1:0] acc;

    // Sum the shifted partial terms selected by the constant numerator.
    always_comb begin
        acc = '0;
        for (int b = 0; b < NUM_BITS; b++) begin
            if (NUM[b]) acc = acc + (v <<< b);
        end
    end

    assign y = acc >>> SH;
endmodule

// File: rtl/bdct_even.sv
// Module: even half (stages 2..4) producing Y0, Y2, Y4, Y6.
// Input a[] is the registered stage-1 sum vector; outputs are registered.
// Assumes: data registers carry no reset; validity is tracked by the top.
module bdct_even #(
    parameter int W      = 17,
    parameter int K3_NUM = 3,
    parameter int K3_SH  = 3,
    parameter int K4_NUM = 3,
    parameter int K4_SH  = 3
) (
    input  logic                clk,
    input  logic signed [W-1:0] a [bdct_pkg::HALF_N],
    output logic signed [W-1:0] y [bdct_pkg::HALF_N]   // Y0, Y2, Y4, Y6
);
    logic signed [W-1:0] e0_q, e1_q, e2_q, e3_q;
    logic signed [W-1:0] dc_q, e1_s3_q, rot_q, e3_s3_q;
    logic signed [W-1:0] lift_e3, lift_rot;

    // Stage 2: second butterfly level of the even half.
    always_ff @(posedge clk) begin
        e0_q <= a[0] + a[3];
        e1_q <= a[1] + a[2];
        e2_q <= a[1] - a[2];
        e3_q <= a[0] - a[3];
    end

    bdct_lift #(.W(W), .NUM(K3_NUM), .SH(K3_SH)) u_lift_k3 (.v(e3_q), .y(lift_e3));

    // Stage 3: DC sum and first lifting step of the even rotation.
    always_ff @(posedge clk) begin
        dc_q    <= e0_q + e1_q;
        e1_s3_q <= e1_q;
        rot_q   <= e2_q - lift_e3;
        e3_s3_q <= e3_q;
    end

    bdct_lift #(.W(W), .NUM(K4_NUM), .SH(K4_SH)) u_lift_k4 (.v(rot_q), .y(lift_rot));

    // Stage 4: half-scale lifting for Y4 and second rotation step for Y2.
    always_ff @(posedge clk) begin
        y[0] <= dc_q;
        y[1] <= e3_s3_q + lift_rot;
        y[2] <= (dc_q >>> 1) - e1_s3_q;
        y[3] <= rot_q;
    end
endmodule

// File: rtl/bdct_odd.sv
// Module: odd half (stages 2..4) producing Y1, Y3, Y5, Y7.
// Input d[] is the registered stage-1 difference vector; outputs are registered.
// Assumes: data registers carry no reset; validity is tracked by the top.
module bdct_odd #(
    parameter int W      = 17,
    parameter int K1_NUM = 13,
    parameter int K1_SH  = 5,
    parameter int K2_NUM = 11,
    parameter int K2_SH  = 4,
    parameter int K5_NUM = 1,
    parameter int K5_SH  = 3,
    parameter int K6_NUM = 1,
    parameter int K6_SH  = 3,
    parameter int K7_NUM = 7,
    parameter int K7_SH  = 4,
    parameter int K8_NUM = 3,
    parameter int K8_SH  = 2
) (
    input  logic                clk,
    input  logic signed [W-1:0] d [bdct_pkg::HALF_N],
    output logic signed [W-1:0] y [bdct_pkg::HALF_N]   // Y1, Y3, Y5, Y7
);
    logic signed [W-1:0] d0_q, d1_q, d3_q, m_q;
    logic signed [W-1:0] b0_q, b1_q, b2_q, b3_q;
    logic signed [W-1:0] lift_d1, lift_m, n_c;
    logic signed [W-1:0] lift_b0, y7_c, lift_y7, lift_b2, y5_c, lift_y5;

    bdct_lift #(.W(W), .NUM(K1_NUM), .SH(K1_SH)) u_lift_k1 (.v(d[1]), .y(lift_d1));

    // Stage 2: first lifting step of the centre rotation.
    always_ff @(posedge clk) begin
        d0_q <= d[0];
        d1_q <= d[1];
        d3_q <= d[3];
        m_q  <= d[2] - lift_d1;
    end

    bdct_lift #(.W(W), .NUM(K2_NUM), .SH(K2_SH)) u_lift_k2 (.v(m_q), .y(lift_m));
    assign n_c = d1_q + lift_m;

    // Stage 3: finish the centre rotation and form the outer butterflies.
    always_ff @(posedge clk) begin
        b0_q <= d0_q + n_c;
        b1_q <= d0_q - n_c;
        b2_q <= d3_q - m_q;
        b3_q <= d3_q + m_q;
    end

    bdct_lift #(.W(W), .NUM(K5_NUM), .SH(K5_SH)) u_lift_k5 (.v(b0_q), .y(lift_b0));
    assign y7_c = lift_b0 - b3_q;
    bdct_lift #(.W(W), .NUM(K6_NUM), .SH(K6_SH)) u_lift_k6 (.v(y7_c), .y(lift_y7));
    bdct_lift #(.W(W), .NUM(K7_NUM), .SH(K7_SH)) u_lift_k7 (.v(b2_q), .y(lift_b2));
    assign y5_c = b1_q + lift_b2;
    bdct_lift #(.W(W), .NUM(K8_NUM), .SH(K8_SH)) u_lift_k8 (.v(y5_c), .y(lift_y5));

    // Stage 4: two-step lifting rotations for the outer odd pairs.
    always_ff @(posedge clk) begin
        y[0] <= b0_q - lift_y7;
        y[1] <= b2_q - lift_y5;
        y[2] <= y5_c;
        y[3] <= y7_c;
    end
endmodule

// File: rtl/bdct_row8.sv
// Module: top of the 8-point multiplierless forward DCT row kernel.
// Stage 1 forms lane sums and differences; even and odd halves run stages 2..4.
// Assumes: OUT_W holds every intermediate for the chosen constants; only the
// valid pipeline is reset (synchronous, active low).
module bdct_row8 #(
    parameter int IN_W   = 9,
    parameter int OUT_W  = 17,
    parameter int K1_NUM = 13, parameter int K1_SH = 5,
    parameter int K2_NUM = 11, parameter int K2_SH = 4,
    parameter int K3_NUM = 3,  parameter int K3_SH = 3,
    parameter int K4_NUM = 3,  parameter int K4_SH = 3,
    parameter int K5_NUM = 1,  parameter int K5_SH = 3,
    parameter int K6_NUM = 1,  parameter int K6_SH = 3,
    parameter int K7_NUM = 7,  parameter int K7_SH = 4,
    parameter int K8_NUM = 3,  parameter int K8_SH = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [bdct_pkg::ROW_N*IN_W-1:0]  in_vec,
    output logic                         out_valid,
    output logic [bdct_pkg::ROW_N*OUT_W-1:0] out_vec
);
    import bdct_pkg::*;

    localparam int EXT_W = OUT_W - IN_W;

    logic signed [OUT_W-1:0] x_w   [ROW_N];
    logic signed [OUT_W-1:0] sum_q [HALF_N];
    logic signed [OUT_W-1:0] dif_q [HALF_N];
    logic signed [OUT_W-1:0] y_ev  [HALF_N];
    logic signed [OUT_W-1:0] y_od  [HALF_N];
    logic [PIPE_LAT-1:0]     vld_q;

    // Sign-extend each input lane to the internal width.
    for (genvar i = 0; i < ROW_N; i++) begin : g_ext
        assign x_w[i] = {{EXT_W{in_vec[i*IN_W+IN_W-1]}}, in_vec[i*IN_W +: IN_W]};
    end

    // Stage 1: mirrored-lane butterflies, all four pairs in parallel.
    always_ff @(posedge clk) begin
        for (int i = 0; i < HALF_N; i++) begin
            sum_q[i] <= x_w[i] + x_w[ROW_N-1-i];
            dif_q[i] <= x_w[i] - x_w[ROW_N-1-i];
        end
    end

    // Valid flag shift register matching the four data stages.
    always_ff @(posedge clk) begin
        if (!rst_n) vld_q <= '0;
        else        vld_q <= {vld_q[PIPE_LAT-2:0], in_valid};
    end

    assign out_valid = vld_q[PIPE_LAT-1];

    bdct_even #(
        .W(OUT_W), .K3_NUM(K3_NUM), .K3_SH(K3_SH), .K4_NUM(K4_NUM), .K4_SH(K4_SH)
    ) u_even (.clk(clk), .a(sum_q), .y(y_ev));

    bdct_odd #(
        .W(OUT_W),
        .K1_NUM(K1_NUM), .K1_SH(K1_SH), .K2_NUM(K2_NUM), .K2_SH(K2_SH),
        .K5_NUM(K5_NUM), .K5_SH(K5_SH), .K6_NUM(K6_NUM), .K6_SH(K6_SH),
        .K7_NUM(K7_NUM), .K7_SH(K7_SH), .K8_NUM(K8_NUM), .K8_SH(K8_SH)
    ) u_odd (.clk(clk), .d(dif_q), .y(y_od));

    // Interleave halves so that output slot k carries frequency k.
    for (genvar k = 0; k < ROW_N; k++) begin : g_out
        if (k % 2 == 0) begin : g_even
            assign out_vec[k*OUT_W +: OUT_W] = y_ev[k/2];
        end else begin : g_odd
            assign out_vec[k*OUT_W +: OUT_W] = y_od[k/2];
        end
    end
endmodule

// File: rtl/bdct_row8_chk.sv
// Checker: cycle-level properties of bdct_row8, attached by bind below.
// Assumes: rst_n is held low from time zero until the first edges.
module bdct_row8_chk #(
    parameter int IN_W  = 9,
    parameter int OUT_W = 17
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         in_valid,
    input logic [bdct_pkg::ROW_N*IN_W-1:0]  in_vec,
    input logic                         out_valid,
    input logic [bdct_pkg::ROW_N*OUT_W-1:0] out_vec
);
    import bdct_pkg::*;

    logic [2:0]              since_rst;
    logic                    dc_in, anti_in, odd_zero, even_zero;
    logic signed [OUT_W-1:0] dc_exp;
    logic signed [OUT_W-1:0] lane [ROW_N];

    // Count edges since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)                       since_rst <= '0;
        else if (since_rst != 3'(PIPE_LAT)) since_rst <= since_rst + 3'd1;
    end

    // Classify the incoming row and the outgoing coefficient halves.
    always_comb begin
        for (int i = 0; i < ROW_N; i++) begin
            lane[i] = OUT_W'($signed(in_vec[i*IN_W +: IN_W]));
        end
        dc_in   = 1'b1;
        anti_in = 1'b1;
        for (int i = 0; i < ROW_N; i++) begin
            if (lane[i] != lane[0]) dc_in = 1'b0;
            if (lane[i] + lane[ROW_N-1-i] != '0) anti_in = 1'b0;
        end
        dc_exp    = lane[0] <<< 3;
        odd_zero  = 1'b1;
        even_zero = 1'b1;
        for (int k = 0; k < ROW_N; k++) begin
            if (out_vec[k*OUT_W +: OUT_W] != '0) begin
                if (k % 2 == 1) odd_zero = 1'b0;
                else            even_zero = 1'b0;
            end
        end
    end

    AST_RST_CLEARS_VALID: assert property (@(posedge clk)
        !rst_n |=> !out_valid);                                   // R1

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3'(PIPE_LAT)) |-> (out_valid == $past(in_valid, 4))); // R2

    AST_ZERO_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_vec, 4) == '0) |-> (out_vec == '0)); // R6

    AST_DC_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(dc_in, 4)) |->
        (odd_zero && $signed(out_vec[0 +: OUT_W]) == $past(dc_exp, 4)
         && out_vec[2*OUT_W +: OUT_W] == '0 && out_vec[4*OUT_W +: OUT_W] == '0
         && out_vec[6*OUT_W +: OUT_W] == '0));                    // R4

    AST_ANTISYM_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(anti_in, 4)) |-> even_zero);          // R5
endmodule

bind bdct_row8 bdct_row8_chk #(.IN_W(IN_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
    .out_valid(out_valid), .out_vec(out_vec)
);

// File: tb/sim_bdct_row8.sv
// Bench: drives rows at the falling edge and compares both instances against
// a model of the R3 equations, with expected rows queued four cycles deep.
module sim_bdct_row8;
    localparam int IN_W  = 9;
    localparam int OUT_W = 17;
    localparam int VW    = 8 * IN_W;
    localparam int OW    = 8 * OUT_W;
    localparam int NTAB  = 10;
    localparam int KA [16] = '{13,5, 11,4, 3,3, 3,3, 1,3, 1,3, 7,4, 3,2};
    localparam int KB [16] = '{5,3, 3,2, 1,1, 5,3, 3,4, 9,4, 1,1, 5,3};
    localparam int TAB [NTAB][8] = '{
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{255, 255, 255, 255, 255, 255, 255, 255},
        '{-256, -256, -256, -256, -256, -256, -256, -256},
        '{255, -256, 255, -256, 255, -256, 255, -256},
        '{10, -20, 30, -40, 40, -30, 20, -10},
        '{0, 32, 64, 96, 128, 160, 192, 224},
        '{-1, -3, -5, -7, -2, -4, -6, -8},
        '{255, 0, 255, 0, 0, 255, 0, 255},
        '{100, -50, 7, -128, 3, 77, -200, 19},
        '{-3, -3, -3, -3, -3, -3, -3, -3}
    };
    localparam string TAGS [NTAB] =
        '{"R6", "R4", "R8", "R8", "R5", "R3", "R7", "R3", "R7", "R4"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [VW-1:0] in_vec = '0;
    logic          out_valid, out_valid_b;
    logic [OW-1:0] out_vec, out_vec_b;

    int checks = 0;
    int errors = 0;

    logic          pv  [4];
    logic [OW-1:0] pda [4];
    logic [OW-1:0] pdb [4];
    string         ptg [4];

    always #4 clk = ~clk;

    bdct_row8 #(.IN_W(IN_W), .OUT_W(OUT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid), .out_vec(out_vec));

    bdct_row8 #(.IN_W(IN_W), .OUT_W(OUT_W),
        .K1_NUM(KB[0]),  .K1_SH(KB[1]),  .K2_NUM(KB[2]),  .K2_SH(KB[3]),
        .K3_NUM(KB[4]),  .K3_SH(KB[5]),  .K4_NUM(KB[6]),  .K4_SH(KB[7]),
        .K5_NUM(KB[8]),  .K5_SH(KB[9]),  .K6_NUM(KB[10]), .K6_SH(KB[11]),
        .K7_NUM(KB[12]), .K7_SH(KB[13]), .K8_NUM(KB[14]), .K8_SH(KB[15])
    ) u1 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_vec(in_vec),
        .out_valid(out_valid_b), .out_vec(out_vec_b));

    function automatic int lf(input int v, input int num, input int sh);
        return (v * num) >>> sh;
    endfunction

    // Model of the R3 equations with floor lifting.
    function automatic logic [OW-1:0] model(input logic [VW-1:0] v, input int k [16]);
        int x [8];
        int a [4];
        int d [4];
        int e0, e1, e2, e3, m, n, b0, b1, b2, b3;
        int y [8];
        logic [OW-1:0] r;
        for (int i = 0; i < 8; i++) x[i] = int'($signed(v[i*IN_W +: IN_W]));
        for (int i = 0; i < 4; i++) begin
            a[i] = x[i] + x[7-i];
            d[i] = x[i] - x[7-i];
        end
        e0 = a[0] + a[3]; e1 = a[1] + a[2]; e2 = a[1] - a[2]; e3 = a[0] - a[3];
        y[0] = e0 + e1;
        y[4] = (y[0] >>> 1) - e1;
        y[6] = e2 - lf(e3, k[4], k[5]);
        y[2] = e3 + lf(y[6], k[6], k[7]);
        m  = d[2] - lf(d[1], k[0], k[1]);
        n  = d[1] + lf(m, k[2], k[3]);
        b0 = d[0] + n; b1 = d[0] - n; b2 = d[3] - m; b3 = d[3] + m;
        y[7] = lf(b0, k[8], k[9]) - b3;
        y[1] = b0 - lf(y[7], k[10], k[11]);
        y[5] = b1 + lf(b2, k[12], k[13]);
        y[3] = b2 - lf(y[5], k[14], k[15]);
        for (int i = 0; i < 8; i++) r[i*OUT_W +: OUT_W] = OUT_W'(y[i]);
        return r;
    endfunction

    function automatic logic [VW-1:0] pack(input int row [8]);
        logic [VW-1:0] r;
        for (int i = 0; i < 8; i++) r[i*IN_W +: IN_W] = IN_W'(row[i]);
        return r;
    endfunction

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: valid act=%b exp=%b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic check_row(input string tag, input logic [OW-1:0] act, input logic [OW-1:0] exp);
        checks++;
        for (int k = 0; k < 8; k++) begin
            if (act[k*OUT_W +: OUT_W] !== exp[k*OUT_W +: OUT_W]) begin
                errors++;
                $display("FAIL %s: Y%0d act=%0d exp=%0d at %0t", tag, k,
                         $signed(act[k*OUT_W +: OUT_W]), $signed(exp[k*OUT_W +: OUT_W]), $time);
                break;
            end
        end
    endtask

    // One falling-edge step: check what leaves now, then offer the next row.
    task automatic step(input logic v, input logic [VW-1:0] vec, input string tag);
        @(negedge clk);
        check_bit("R2", out_valid, pv[3]);
        check_bit("R10", out_valid_b, pv[3]);
        if (pv[3]) begin
            check_row(ptg[3], out_vec, pda[3]);
            check_row("R10", out_vec_b, pdb[3]);
        end
        for (int s = 3; s > 0; s--) begin
            pv[s] = pv[s-1]; pda[s] = pda[s-1]; pdb[s] = pdb[s-1]; ptg[s] = ptg[s-1];
        end
        in_valid = v;
        in_vec   = vec;
        pv[0]  = v;
        pda[0] = model(vec, KA);
        pdb[0] = model(vec, KB);
        ptg[0] = tag;
    endtask

    task automatic drain();
        for (int i = 0; i < 5; i++) step(1'b0, '0, "R9");
    endtask

    // Reset with a row offered throughout; R1 says nothing of it survives.
    task automatic do_reset(input int cycles);
        @(negedge clk);
        rst_n = 1'b0;
        in_valid = 1'b1;
        in_vec = pack(TAB[1]);
        for (int s = 0; s < 4; s++) pv[s] = 1'b0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            check_bit("R1", out_valid, 1'b0);
        end
        rst_n = 1'b1;
        in_valid = 1'b0;
    endtask

    initial begin
        for (int s = 0; s < 4; s++) begin
            pv[s] = 1'b0; pda[s] = '0; pdb[s] = '0; ptg[s] = "R2";
        end
        do_reset(3);
        drain();

        // Table rows, back to back (R2 throughput).
        for (int t = 0; t < NTAB; t++) step(1'b1, pack(TAB[t]), TAGS[t]);
        drain();

        // Random rows over the full input range, back to back (R3, R8).
        for (int t = 0; t < 40; t++) begin
            int row [8];
            for (int i = 0; i < 8; i++) row[i] = int'($urandom_range(0, 511)) - 256;
            step(1'b1, pack(row), "R3");
        end
        drain();

        // Gapped rows: idle cycles must stay idle at the output (R9).
        step(1'b1, pack(TAB[8]), "R9");
        step(1'b0, pack(TAB[3]), "R9");
        step(1'b1, pack(TAB[6]), "R9");
        step(1'b0, pack(TAB[2]), "R9");
        step(1'b0, pack(TAB[1]), "R9");
        step(1'b1, pack(TAB[5]), "R9");
        drain();

        // Mid-stream reset: rows in flight are dropped (R1).
        step(1'b1, pack(TAB[7]), "R1");
        step(1'b1, pack(TAB[8]), "R1");
        do_reset(2);
        drain();

        // Negative-heavy rows exercise floor rounding (R7).
        step(1'b1, pack('{-1, -1, -1, -2, 0, 0, 0, 0}), "R7");
        step(1'b1, pack('{-255, 1, -7, 3, -9, 5, -11, 13}), "R7");
        step(1'b1, pack('{-256, 255, 255, -256, -256, 255, 255, -256}), "R8");
        drain();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 20000);
        errors++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule